// File: doc/BRIEF.md
# Software-Pipelined Loop Level Scheduler

This block controls which pipeline levels of a repeating microcoded cycle may run on each pass of a loop. Every operation in the cycle has a 3-bit level tag. The block produces one enable bit for each level from 1 to 7. Each new item that enters the loop begins at level 1 and climbs one level per pass. As a result, an operation tagged k first runs on the k-th pass and keeps running on every later pass.

The block takes five kinds of input:
- a pass-start pulse;
- a wind-down command, which stops new items from entering;
- a quit command from an execution thread, which carries a level;
- a finish command, which carries a level and caps the highest level allowed;
- a restart command, which clears all state.

A branch that keeps the pipeline state is simply a cycle with none of these inputs, and it leaves the enable set untouched. The block also decodes a single tag against the current enable set, and it raises a sticky drained flag once no level can run again.

Top module: `pipe_level_sched`

## Requirements
- R1: After a reset (rst_n low at a clock edge), every level enable is 0, op_en is 0, drained is 0 and the upper limit is 7. Restart, applied at a clock edge, sets the same state.
- R2: op_en is 1 only when op_tag is between 1 and 7 and bit op_tag-1 of level_en is set. A tag of 0 never gives op_en.
- R3: Each pass-start shifts the set of live items up one level (level_en bit k-1 is level k). A new item enters level 1 unless drain is active, and an item that leaves level 7 is dropped. So with no commands, level k is first enabled on the k-th pass.
- R4: After wind-down, no new item enters level 1 from the next pass-start onward. The lowest enabled level therefore rises by one on each later pass, and drain stays active until restart.
- R5: Quit at level q (1 to 7) disables level q from the next clock edge. The disabled slot climbs one level with each later pass. Quit also activates drain, exactly as R4 does.
- R6: Finish at level d (1 to 7) sets the upper limit for the next pass to the smaller of its pending value and d+1 (capped at 7). After that the limit drops by one per pass, down to a floor of 0. The limit of the current pass does not change. Levels above the limit are disabled.
- R7: A wind-down, quit or finish in the same cycle as a pass-start belongs to the pass being started. That pass still admits a new item, and a quit in that cycle removes that pass's item at level q.
- R8: In a cycle with no pass-start, quit or restart, level_en keeps its value.
- R9: drained rises at a pass-start when drain or finish was already active before that cycle and the enable set of the new pass is empty. It then stays high until reset or restart.
- R10: Restart overrides every other input in the same cycle, including a pass-start.
- R11: A quit or finish whose level field is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| restart_i | input | 1 | Clear all state and begin filling again from level 1 |
| pass_start_i | input | 1 | Pulse that starts a new loop pass |
| wind_down_i | input | 1 | Stop admitting new items |
| quit_i | input | 1 | Thread quit command |
| quit_lvl_i | input | 3 | Level of the quitting thread |
| finish_i | input | 1 | Finish-current-item command |
| finish_lvl_i | input | 3 | Level that decided to finish |
| op_tag_i | input | 3 | Level tag to decode |
| level_en_o | output | 7 | Enable for levels 1..7 (bit k-1 = level k) |
| op_en_o | output | 1 | Enable for the operation tagged op_tag_i |
| drained_o | output | 1 | Sticky: no level can run again |

## Verification
Two functions can fall in the same cycle: a pass-start together with a quit, a wind-down or a finish. In that case the shift and the command must compose in the defined order. The bench provokes this by issuing each command on the same edge as a pass-start, and also on an edge that is not a pass-start. It judges the result by comparing level_en, op_en and drained on every cycle against a model that tracks each item's age in a queue. A restart together with a pass-start is checked the same way, to show that the pass-start is discarded.

// File: rtl/pls_pkg.sv
// Package for the loop level scheduler.
// Provides the default level count and a record of the decoded command strobes.
package pls_pkg;
    localparam int unsigned PLS_DEF_LEVELS = 7;

    typedef struct packed {
        logic restart;
        logic start;
        logic wind;
    } pls_ctl_t;
endpackage

// File: rtl/pls_live_shift.sv
// Shift register of live items, one bit per level.
// A pass-start moves each item up one level and inserts a new item at level 1
// when inject is high. A one-hot quit clears the addressed level.
// Assumes: quit_oh has at most one bit set; restart takes priority over everything.
module pls_live_shift #(
    parameter int unsigned N = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  pls_pkg::pls_ctl_t    ctl,
    input  logic                 inject,
    input  logic [N-1:0]         quit_oh,
    output logic [N-1:0]         live_q,
    output logic [N-1:0]         live_d
);
    // Next-state: shift on a pass-start, then apply the quit, with restart winning.
    always_comb begin
        live_d = live_q;
        if (ctl.start) begin
            live_d = {live_q[N-2:0], inject};
        end
        live_d = live_d & ~quit_oh;
        if (ctl.restart) begin
            live_d = '0;
        end
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= '0;
        end else begin
            live_q <= live_d;
        end
    end

    // R3: after a shift, the upper bits can only come from the bits below them.
    a_r3_shift_source: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.start && !ctl.restart) |=> ((live_q[N-1:1] & ~$past(live_q[N-2:0])) == '0));

    // R4: when drain is active, no item enters level 1.
    a_r4_no_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.start && !inject && !ctl.restart) |=> !live_q[0]);

    // R5: a quitting level is off after the edge.
    a_r5_quit_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ((quit_oh != '0) && !ctl.restart) |=> ((live_q & $past(quit_oh)) == '0));

    // R8: with no event, the register holds its value.
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.start && !ctl.restart && (quit_oh == '0)) |=> $stable(live_q));

    // R1: restart empties the register.
    a_r1_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.restart |=> (live_q == '0));
endmodule

// File: rtl/pls_upper_limit.sv
// Upper-limit tracker. It holds the limit of the running pass and the
// pending limit for the next pass. A finish command lowers the pending limit;
// after that the limit falls by one per pass.
// Assumes: fin_oh has at most one bit set.
module pls_upper_limit #(
    parameter int unsigned N  = 7,
    parameter int unsigned TW = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  pls_pkg::pls_ctl_t    ctl,
    input  logic [N-1:0]         fin_oh,
    output logic [TW-1:0]        hi_cur_q,
    output logic [TW-1:0]        hi_cur_d,
    output logic                 shrink_q
);
    logic [TW-1:0] hi_nxt_q, hi_nxt_d, cand;
    logic          shrink_d;

    // Candidate limit: one above the deciding level, capped at N.
    always_comb begin
        cand = TW'(N);
        for (int k = 0; k < N; k++) begin
            if (fin_oh[k]) begin
                cand = (k + 1 == N) ? TW'(N) : TW'(k + 2);
            end
        end
    end

    // Next-state: promote the pending limit, shrink it, apply finish; restart wins.
    always_comb begin
        hi_cur_d = hi_cur_q;
        hi_nxt_d = hi_nxt_q;
        shrink_d = shrink_q;
        if (ctl.start) begin
            hi_cur_d = hi_nxt_q;
            if (shrink_q && (hi_nxt_q != '0)) begin
                hi_nxt_d = hi_nxt_q - 1'b1;
            end
        end
        if (fin_oh != '0) begin
            if (cand < hi_nxt_d) begin
                hi_nxt_d = cand;
            end
            shrink_d = 1'b1;
        end
        if (ctl.restart) begin
            hi_cur_d = TW'(N);
            hi_nxt_d = TW'(N);
            shrink_d = 1'b0;
        end
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cur_q <= TW'(N);
            hi_nxt_q <= TW'(N);
            shrink_q <= 1'b0;
        end else begin
            hi_cur_q <= hi_cur_d;
            hi_nxt_q <= hi_nxt_d;
            shrink_q <= shrink_d;
        end
    end

    // R6: once shrinking, the pending limit never rises.
    a_r6_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (shrink_q && !ctl.restart) |=> (hi_nxt_q <= $past(hi_nxt_q)));

    // R6: the running pass keeps its limit until the next pass-start.
    a_r6_cur_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.start && !ctl.restart) |=> $stable(hi_cur_q));

    // R1: restart reopens the limit.
    a_r1_limit_reset: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.restart |=> (hi_cur_q == TW'(N) && !shrink_q));
endmodule

// File: rtl/pls_drain_ctrl.sv
// Drain and completion control. Latches the drain state from wind-down or quit,
// and raises a sticky drained flag when a pass starts with nothing enabled
// after drain or finish was already active.
// Assumes: next_en is the enable set of the pass being started.
module pls_drain_ctrl #(
    parameter int unsigned N = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  pls_pkg::pls_ctl_t    ctl,
    input  logic                 quit_hit,
    input  logic                 shrink_q,
    input  logic [N-1:0]         next_en,
    output logic                 draining_q,
    output logic                 done_q
);
    logic draining_d, done_d;

    // Next-state for the drain and done flags.
    always_comb begin
        draining_d = draining_q | ctl.wind | quit_hit;
        done_d     = done_q | (ctl.start && (draining_q || shrink_q) && (next_en == '0));
        if (ctl.restart) begin
            draining_d = 1'b0;
            done_d     = 1'b0;
        end
    end

    // Flag registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            draining_q <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            draining_q <= draining_d;
            done_q     <= done_d;
        end
    end

    // R9: drained is sticky until restart.
    a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !ctl.restart) |=> done_q);

    // R4: drain stays active until restart.
    a_r4_drain_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (draining_q && !ctl.restart) |=> draining_q);
endmodule

// File: rtl/pipe_level_sched.sv
// Top of the loop level scheduler. Decodes the quit and finish levels to
// one-hot form, combines the live-item register with the upper limit to form
// the per-level enables, and decodes one operation tag against them.
// Assumes: level fields use 0 for "none" and 1..N for levels.
module pipe_level_sched #(
    parameter int unsigned N  = pls_pkg::PLS_DEF_LEVELS,
    parameter int unsigned TW = $clog2(N + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           restart_i,
    input  logic           pass_start_i,
    input  logic           wind_down_i,
    input  logic           quit_i,
    input  logic [TW-1:0]  quit_lvl_i,
    input  logic           finish_i,
    input  logic [TW-1:0]  finish_lvl_i,
    input  logic [TW-1:0]  op_tag_i,
    output logic [N-1:0]   level_en_o,
    output logic           op_en_o,
    output logic           drained_o
);
    pls_pkg::pls_ctl_t ctl;
    logic [N-1:0]      quit_oh, fin_oh, live_q, live_d;
    logic [TW-1:0]     hi_cur_q, hi_cur_d;
    logic              shrink_q, draining_q, quit_hit;

    // Mask of levels at or below a limit.
    function automatic logic [N-1:0] below_mask(input logic [TW-1:0] h);
        logic [N-1:0] m;
        for (int k = 0; k < N; k++) begin
            m[k] = ((k + 1) <= int'(h));
        end
        return m;
    endfunction

    // Pack the command strobes.
    always_comb begin
        ctl.restart = restart_i;
        ctl.start   = pass_start_i;
        ctl.wind    = wind_down_i;
    end

    // One-hot decode of the quit and finish levels; level 0 decodes to nothing.
    for (genvar g = 0; g < N; g++) begin : g_lvl_dec
        assign quit_oh[g] = quit_i   && (quit_lvl_i   == TW'(g + 1));
        assign fin_oh[g]  = finish_i && (finish_lvl_i == TW'(g + 1));
    end
    assign quit_hit = |quit_oh;

    pls_live_shift #(.N(N)) u_live (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl     (ctl),
        .inject  (!draining_q),
        .quit_oh (quit_oh),
        .live_q  (live_q),
        .live_d  (live_d)
    );

    pls_upper_limit #(.N(N), .TW(TW)) u_upper (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl      (ctl),
        .fin_oh   (fin_oh),
        .hi_cur_q (hi_cur_q),
        .hi_cur_d (hi_cur_d),
        .shrink_q (shrink_q)
    );

    pls_drain_ctrl #(.N(N)) u_drain (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl        (ctl),
        .quit_hit   (quit_hit),
        .shrink_q   (shrink_q),
        .next_en    (live_d & below_mask(hi_cur_d)),
        .draining_q (draining_q),
        .done_q     (drained_o)
    );

    // Per-level enables: items that are live and within the upper limit.
    assign level_en_o = live_q & below_mask(hi_cur_q);

    // Decode a single tag against the enable set.
    always_comb begin
        op_en_o = 1'b0;
        for (int k = 0; k < N; k++) begin
            if (op_tag_i == TW'(k + 1)) begin
                op_en_o = level_en_o[k];
            end
        end
    end

    // R2: a tag of 0 is never enabled.
    a_r2_tag0_never: assert property (@(posedge clk) disable iff (!rst_n)
        (op_tag_i == '0) |-> !op_en_o);

    // R10: restart wins over a same-cycle pass-start.
    a_r10_restart_wins: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> ((level_en_o == '0) && !drained_o));

    // R11: a quit with level 0 leaves the enables alone when nothing else happens.
    a_r11_quit_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (quit_i && (quit_lvl_i == '0) && !pass_start_i && !restart_i) |=> $stable(level_en_o));
endmodule

// File: tb/test_pipe_level_sched.sv
// Bench: a queue-of-item-ages reference model, compared at every falling edge.
module test_pipe_level_sched;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       restart_i = 0, pass_start_i = 0, wind_down_i = 0;
    logic       quit_i = 0, finish_i = 0;
    logic [2:0] quit_lvl_i = 0, finish_lvl_i = 0, op_tag_i = 0;
    logic [6:0] level_en_o;
    logic       op_en_o, drained_o;

    int tests = 0, fails = 0;
    string req = "R1";

    // Model state.
    int ages[$];
    bit m_drain, m_shrink, m_done;
    int m_hicur, m_hinxt;

    always #5 clk = ~clk;

    pipe_level_sched i_pipe_level_sched (
        .clk(clk), .rst_n(rst_n), .restart_i(restart_i), .pass_start_i(pass_start_i),
        .wind_down_i(wind_down_i), .quit_i(quit_i), .quit_lvl_i(quit_lvl_i),
        .finish_i(finish_i), .finish_lvl_i(finish_lvl_i), .op_tag_i(op_tag_i),
        .level_en_o(level_en_o), .op_en_o(op_en_o), .drained_o(drained_o)
    );

    function automatic bit has_age(int a);
        foreach (ages[i]) if (ages[i] == a) return 1;
        return 0;
    endfunction

    function automatic logic [6:0] exp_en();
        logic [6:0] e = '0;
        for (int k = 1; k <= 7; k++) e[k-1] = has_age(k) && (k <= m_hicur);
        return e;
    endfunction

    task automatic m_clear();
        ages.delete();
        m_drain = 0; m_shrink = 0; m_done = 0; m_hicur = 7; m_hinxt = 7;
    endtask

    // One clock of model behaviour, taken from the requirements.
    task automatic m_step(bit rs, bit st, bit wd, bit qv, int ql, bit fv, int fl);
        bit od, os;
        int tmp[$];
        if (rs) begin m_clear(); return; end
        od = m_drain; os = m_shrink;
        if (st) begin
            tmp.delete();
            foreach (ages[i]) if (ages[i] + 1 <= 7) tmp.push_back(ages[i] + 1);
            ages = tmp;
            if (!od) ages.push_back(1);
            m_hicur = m_hinxt;
            if (os && m_hinxt > 0) m_hinxt--;
        end
        if (qv && ql >= 1 && ql <= 7) begin
            tmp.delete();
            foreach (ages[i]) if (ages[i] != ql) tmp.push_back(ages[i]);
            ages = tmp;
            m_drain = 1;
        end
        if (wd) m_drain = 1;
        if (fv && fl >= 1 && fl <= 7) begin
            int c = (fl == 7) ? 7 : fl + 1;
            if (c < m_hinxt) m_hinxt = c;
            m_shrink = 1;
        end
        if (st && (od || os) && exp_en() == '0) m_done = 1;
    endtask

    task automatic check();
        logic [6:0] e = exp_en();
        logic eo = (op_tag_i != 0) && e[op_tag_i - 1];
        tests++;
        if (level_en_o !== e) begin
            fails++;
            $display("FAIL %s level_en act %b exp %b", req, level_en_o, e);
        end
        tests++;
        if (op_en_o !== eo) begin
            fails++;
            $display("FAIL %s op_en tag %0d act %b exp %b", req, op_tag_i, op_en_o, eo);
        end
        tests++;
        if (drained_o !== m_done) begin
            fails++;
            $display("FAIL %s drained act %b exp %b", req, drained_o, m_done);
        end
    endtask

    // Drive one cycle, step the model at the edge, compare at the falling edge.
    task automatic cyc(bit st, bit wd = 0, bit qv = 0, int ql = 0, bit fv = 0, int fl = 0, bit rs = 0);
        restart_i = rs; pass_start_i = st; wind_down_i = wd;
        quit_i = qv; quit_lvl_i = 3'(ql); finish_i = fv; finish_lvl_i = 3'(fl);
        op_tag_i = op_tag_i + 3'd1;
        @(posedge clk);
        m_step(rs, st, wd, qv, ql, fv, fl);
        @(negedge clk);
        check();
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        m_clear();
        repeat (2) @(posedge clk);
        @(negedge clk);
        req = "R1"; check();
        rst_n = 1'b1;

        // R3 fill over more than 7 passes, with idle cycles for R8 and a tag sweep for R2.
        req = "R3";
        for (int p = 0; p < 9; p++) begin cyc(1); req = "R8"; cyc(0); req = "R3"; end
        req = "R2"; for (int t = 0; t < 8; t++) cyc(0);

        // R4: wind-down off a pass-start, then drain to the end (R9).
        req = "R4"; cyc(0, 1);
        for (int p = 0; p < 9; p++) cyc(1);
        req = "R9"; cyc(1); cyc(0);

        // R1 and R10: restart together with a pass-start.
        req = "R10"; cyc(1, 0, 0, 0, 0, 0, 1);
        req = "R1"; cyc(0);

        // R5: quit at level 2, not on a pass-start.
        req = "R5"; cyc(1); cyc(1); cyc(1);
        cyc(0, 0, 1, 2);
        for (int p = 0; p < 9; p++) cyc(1);

        // R6: finish at level 3 once the pipeline is full.
        req = "R6"; cyc(0, 0, 0, 0, 0, 0, 1);
        for (int p = 0; p < 8; p++) cyc(1);
        cyc(0, 0, 0, 0, 1, 3);
        for (int p = 0; p < 6; p++) cyc(1);
        req = "R9"; cyc(1); cyc(1);

        // R7: commands on the same edge as a pass-start.
        req = "R7"; cyc(0, 0, 0, 0, 0, 0, 1);
        for (int p = 0; p < 4; p++) cyc(1);
        cyc(1, 0, 1, 1);
        for (int p = 0; p < 3; p++) cyc(1);
        cyc(0, 0, 0, 0, 0, 0, 1);
        for (int p = 0; p < 5; p++) cyc(1);
        cyc(1, 1);
        for (int p = 0; p < 3; p++) cyc(1);
        cyc(0, 0, 0, 0, 0, 0, 1);
        for (int p = 0; p < 7; p++) cyc(1);
        cyc(1, 0, 0, 0, 1, 7);
        cyc(1, 0, 0, 0, 1, 2);
        for (int p = 0; p < 6; p++) cyc(1);

        // R11: level 0 in quit or finish has no effect.
        req = "R11"; cyc(0, 0, 0, 0, 0, 0, 1);
        for (int p = 0; p < 4; p++) cyc(1);
        cyc(0, 0, 1, 0); cyc(0, 0, 0, 0, 1, 0);
        for (int p = 0; p < 5; p++) cyc(1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule